// File: doc/BRIEF.md
# Late-Write Pipelined Burst SRAM

This block is a synchronous single-port SRAM model. It has a pipelined read path and a late-write path, so reads and writes can follow one another on consecutive clocks with no idle cycle between them. Address and control are sampled on the rising clock edge. A new command is loaded when the advance/load input is LOW. When that input is HIGH, the previous command continues as a four-beat burst on the two lowest address bits. The data bus is bidirectional and split into 9-bit lanes, each made of one data byte plus its parity bit.

A write's data is taken from the bus at the second active edge after its command. Read data is driven during the cycle that follows the first active edge after the read command. A read issued right after a write to the same word gets the freshly arriving bytes merged over the stored word. The caller therefore never has to insert a turnaround gap.

Top module: `lw_burst_sram`

## Requirements
- R1: When adv_ld is LOW and any chip enable is inactive (ce1_n HIGH, ce2 LOW or ce3_n HIGH), the cycle performs no access and no data is later driven for it.
- R2: A read command (chips selected, adv_ld LOW, we_n HIGH) at active edge k drives the stored word for its address on dq after active edge k+1, until active edge k+2, provided oe_n is LOW.
- R3: oe_n HIGH keeps dq released at any time, so a read issued or output with oe_n HIGH is a dummy read with no effect on the bus or the array.
- R4: A write command (we_n LOW) at active edge k stores the dq value present at active edge k+2 into the lanes whose bw_n bit is LOW. Bit i of bw_n governs dq[9i+8:9i], and all bw_n bits HIGH writes nothing.
- R5: adv_ld HIGH continues the last loaded command: a read or write burst advances to the next beat and keeps the upper address bits, while a deselect stays idle. bw_n is sampled again on every write beat.
- R6: With burst_lin HIGH the low two address bits of beat n are (start + n) mod 4. With burst_lin LOW they are start XOR n. Start is the low two bits of the loaded address and n counts 0 to 3 and wraps.
- R7: Reads and writes may alternate on consecutive edges. A read of a word whose write data has not yet reached the array returns the new lanes merged over the old ones.
- R8: An edge with cen_n HIGH is ignored entirely: no command, burst step, data capture or output change takes place.
- R9: While sleep is HIGH, new commands and burst steps are ignored and dq is released. Array contents are kept.
- R10: After rst_n is held LOW for a clock, no operation is in flight and dq is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset of the pipeline control, active LOW |
| cen_n | input | 1 | Clock enable, active LOW |
| ce1_n | input | 1 | Chip enable, active LOW |
| ce2 | input | 1 | Chip enable, active HIGH |
| ce3_n | input | 1 | Chip enable, active LOW |
| adv_ld | input | 1 | HIGH continues burst, LOW loads a new command |
| we_n | input | 1 | Write enable, active LOW |
| bw_n | input | NB | Lane write selects, active LOW |
| oe_n | input | 1 | Output enable, active LOW, asynchronous |
| sleep | input | 1 | Sleep request, active HIGH |
| burst_lin | input | 1 | Burst order: HIGH linear, LOW interleaved |
| addr | input | AW | Word address |
| dq | inout | 9*NB | Data bus, 9 bits per lane |

## Verification
The bench builds the block with AW=5 and NB=3. A 32-word array can then be fully written at the start, so every later read, whether directed or random, returns a known word. Three lanes give a middle lane whose mask bit is neither the lowest nor the highest bit. The small address space also makes back-to-back hits on a word with a pending write frequent under random traffic, and that traffic mixes stalls, sleep and both burst orders.

// File: rtl/lw_burst_sram.sv
`timescale 1ns/1ps
module lw_burst_sram #(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cen_n,
  input  logic            ce1_n,
  input  logic            ce2,
  input  logic            ce3_n,
  input  logic            adv_ld,
  input  logic            we_n,
  input  logic [NB-1:0]   bw_n,
  input  logic            oe_n,
  input  logic            sleep,
  input  logic            burst_lin,
  input  logic [AW-1:0]   addr,
  inout  wire  [NB*9-1:0] dq
);
  localparam int LW    = 9;
  localparam int DW    = NB * LW;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_t;

  logic [DW-1:0] mem [DEPTH];

  op_t           b_op, s1_op, s2_op, c_op;
  logic [AW-3:0] b_hi;
  logic [1:0]    b_start, b_cnt, nxt_cnt, nxt_low;
  logic [AW-1:0] s1_addr, s2_addr, c_addr;
  logic [NB-1:0] s1_bw, s2_bw;
  logic [DW-1:0] q_reg, lane_m, wr_word, rd_word;

  wire sel = !ce1_n && ce2 && !ce3_n;

  assign nxt_cnt = b_cnt + 2'd1;
  assign nxt_low = burst_lin ? b_start + nxt_cnt : b_start ^ nxt_cnt;

  always_comb begin
    if (sleep) begin
      c_op   = OP_NONE;
      c_addr = addr;
    end else if (!adv_ld) begin
      c_op   = !sel ? OP_NONE : (we_n ? OP_RD : OP_WR);
      c_addr = addr;
    end else begin
      c_op   = b_op;
      c_addr = {b_hi, nxt_low};
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_m[i*LW +: LW] = {LW{~s2_bw[i]}};
  end

  assign wr_word = (dq & lane_m) | (mem[s2_addr] & ~lane_m);
  assign rd_word = (s2_op == OP_WR && s2_addr == s1_addr) ? wr_word : mem[s1_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_op    <= OP_NONE;
      s1_op   <= OP_NONE;
      s2_op   <= OP_NONE;
      b_hi    <= '0;
      b_start <= '0;
      b_cnt   <= '0;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_bw   <= '1;
      s2_bw   <= '1;
    end else if (!cen_n) begin
      s1_op   <= c_op;
      s1_addr <= c_addr;
      s1_bw   <= bw_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      if (!sleep) begin
        if (!adv_ld) begin
          b_op    <= c_op;
          b_hi    <= addr[AW-1:2];
          b_start <= addr[1:0];
          b_cnt   <= 2'd0;
        end else begin
          b_cnt   <= nxt_cnt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cen_n && s2_op == OP_WR) mem[s2_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cen_n && s1_op == OP_RD) q_reg <= rd_word;
  end

  assign dq = (s2_op == OP_RD && !oe_n && !sleep) ? q_reg : 'z;

  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !sleep && !adv_ld && !sel) |=> (s1_op == OP_NONE)); // R1
  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && s1_op == OP_RD) |=> (s2_op == OP_RD)); // R2
  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !sleep && adv_ld) |=> $stable(b_hi)); // R5
  AST_CEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(s1_op) && $stable(s2_op) && $stable(s1_addr) && $stable(b_cnt))); // R8
  AST_SLEEP_NOCMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && sleep) |=> (s1_op == OP_NONE)); // R9
endmodule

// File: tb/lw_burst_sram_tb_top.sv
`timescale 1ns/1ps
module lw_burst_sram_tb_top;
  localparam int AW = 5;
  localparam int NB = 3;
  localparam int DW = NB * 9;
  localparam logic [2:0] SEL = 3'b010;

  logic clk = 0;
  logic rst_n = 0, cen_n = 0, ce1_n = 1, ce2 = 0, ce3_n = 1, adv_ld = 0, we_n = 1;
  logic oe_n = 0, sleep = 0, burst_lin = 1;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] tb_val = '0;
  logic tb_en = 1;
  wire  [DW-1:0] dq;

  assign dq = tb_en ? tb_val : 'z;
  always #2.5 clk = ~clk;

  lw_burst_sram #(.AW(AW), .NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep),
    .burst_lin(burst_lin), .addr(addr), .dq(dq));

  int nchk = 0, nfail = 0, wseq = 0;
  bit done = 0;
  string tag = "R10";
  logic [DW-1:0] mmem [1<<AW];
  int p1_kind = 0, p2_kind = 0, mb_kind = 0, mb_hi = 0, mb_start = 0, mb_beat = 0;
  logic [DW-1:0] p1_data = '0, p2_data = '0;

  function automatic logic [DW-1:0] gen(input int s);
    logic [DW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*9 +: 9] = 9'((s * 73 + i * 29 + 17) % 511 + 1);
    return r;
  endfunction

  task automatic model_edge();
    int k, a;
    logic [DW-1:0] d;
    k = 0; a = 0; d = '0;
    if (sleep) k = 0;
    else if (!adv_ld) begin
      k = (!ce1_n && ce2 && !ce3_n) ? (we_n ? 1 : 2) : 0;
      mb_kind = k; mb_hi = int'(addr) / 4; mb_start = int'(addr) % 4; mb_beat = 0;
      a = int'(addr);
    end else begin
      k = mb_kind;
      mb_beat = (mb_beat + 1) % 4;
      a = mb_hi * 4 + (burst_lin ? (mb_start + mb_beat) % 4 : (mb_start ^ mb_beat));
    end
    if (k == 2) begin
      wseq++;
      d = gen(wseq);
      for (int i = 0; i < NB; i++) if (!bw_n[i]) mmem[a][i*9 +: 9] = d[i*9 +: 9];
    end else if (k == 1) d = mmem[a];
    p2_kind = p1_kind; p2_data = p1_data;
    p1_kind = k;       p1_data = d;
  endtask

  task automatic step(input logic icen, input logic iadv, input logic iwe, input logic [2:0] ice,
                      input logic [NB-1:0] ibw, input logic [AW-1:0] ia);
    logic [DW-1:0] exp;
    @(negedge clk);
    cen_n = icen; adv_ld = iadv; we_n = iwe; {ce1_n, ce2, ce3_n} = ice; bw_n = ibw; addr = ia;
    tb_en  = !(p2_kind == 1 && !oe_n && !sleep);
    tb_val = (p2_kind == 2) ? p2_data : '0;
    #1;
    exp = tb_en ? tb_val : p2_data;
    nchk++;
    if (dq !== exp) begin
      nfail++;
      $display("FAIL %s t=%0t dq=%h expected=%h", tag, $time, dq, exp);
    end
    @(posedge clk);
    if (!cen_n && rst_n) model_edge();
    #1;
  endtask

  task automatic rd(input int a);                       step(0, 0, 1, SEL, '1, AW'(a)); endtask
  task automatic wr(input int a, input logic [NB-1:0] b); step(0, 0, 0, SEL, b, AW'(a));  endtask
  task automatic cont(input logic [NB-1:0] b);           step(0, 1, 1, SEL, b, '0);      endtask
  task automatic desel(input logic [2:0] c);             step(0, 0, 1, c, '1, '0);       endtask
  task automatic stall();                                step(1, 0, 0, SEL, '0, '1);     endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) desel(3'b110); endtask

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R10"; idle(3);                                   // R10 bus released after reset

    tag = "R4"; burst_lin = 1;                              // R4/R5 fill all words by linear bursts
    for (int b = 0; b < 8; b++) begin wr(b * 4, '0); cont('0); cont('0); cont('0); end
    idle(2);

    tag = "R2";                                             // R2 single reads
    rd(0); rd(7); rd(31); rd(13); idle(2);
    tag = "R3"; oe_n = 1; rd(5); rd(6); idle(2); oe_n = 0;  // R3 dummy reads
    rd(9); @(negedge clk); oe_n = 1; idle(2); oe_n = 0;     // R3 oe raised during output

    tag = "R1";                                             // R1 each enable off
    desel(3'b110); desel(3'b000); desel(3'b011); rd(3); desel(3'b110); cont('1); cont('1); idle(2);
    step(0, 0, 0, 3'b110, '0, 5'd4); idle(2); rd(4); idle(2); // R1 deselected write stores nothing

    tag = "R4";                                             // R4 lane masks
    wr(8, 3'b110); wr(9, 3'b101); wr(10, 3'b011); wr(11, 3'b111); wr(12, 3'b010); idle(2);
    rd(8); rd(9); rd(10); rd(11); rd(12); idle(2);

    tag = "R5";                                             // R5 per-beat lane selects, continued reads
    wr(16, 3'b000); cont(3'b110); cont(3'b101); cont(3'b011); idle(2);
    rd(16); cont('1); cont('1); cont('1); cont('1); cont('1); idle(2);
    desel(3'b000); cont('1); cont('1); idle(2);             // R5 continued deselect

    tag = "R6"; burst_lin = 0;                              // R6 interleaved order
    rd(21); cont('1); cont('1); cont('1);
    rd(26); cont('1); cont('1); cont('1);
    wr(15, '0); cont('0); cont(3'b001); cont('0); idle(2);
    rd(12); cont('1); cont('1); cont('1); idle(2);
    burst_lin = 1; rd(23); cont('1); cont('1); cont('1); idle(2); // R6 linear wrap from 3

    tag = "R7";                                             // R7 back-to-back and forwarding
    wr(2, '0); rd(2); wr(2, 3'b101); rd(2); rd(2); wr(3, 3'b010); rd(3);
    wr(30, '0); rd(29); rd(30); wr(1, '0); wr(1, 3'b011); rd(1); idle(2);

    tag = "R8";                                             // R8 stalls in every phase
    wr(6, '0); stall(); rd(6); stall(); stall(); rd(7); stall(); cont('1); stall(); idle(1);
    wr(18, '0); cont(3'b100); stall(); cont('0); stall(); stall(); cont('0); idle(2); rd(18); cont('1); idle(2);

    tag = "R9";                                             // R9 sleep
    rd(0); sleep = 1; desel(3'b110);
    wr(0, '0); wr(1, '0); rd(2); cont('0); idle(2); sleep = 0;
    rd(0); rd(1); idle(2);

    tag = "R7";                                             // random traffic, both orders
    for (int m = 0; m < 2; m++) begin
      burst_lin = (m == 0);
      for (int n = 0; n < 600; n++) begin
        int r;
        r = $urandom % 16;
        oe_n  = ($urandom % 6 == 0);
        sleep = ($urandom % 15 == 0);
        if (r < 4)       rd($urandom % 32);
        else if (r < 8)  wr($urandom % 32, NB'($urandom));
        else if (r < 12) cont(NB'($urandom));
        else if (r == 12) desel(($urandom % 2) ? 3'b000 : 3'b011);
        else if (r == 13) stall();
        else             desel(3'b110);
      end
      oe_n = 0; sleep = 0; idle(3);
    end

    tag = "R10";                                            // R10 reset mid-burst
    rd(5); cont('1);
    @(negedge clk); rst_n = 0; @(posedge clk); #1;
    rst_n = 1; p1_kind = 0; p2_kind = 0; mb_kind = 0;
    idle(1); cont('1); cont('1); idle(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule